// File: doc/BRIEF.md
# On/Off Cycle Pulse-Width Modulator

This block produces a single pulse-width modulated pin whose waveform is set by two counts: the number of input clocks the pin stays high and the number it stays low. Together they make one period. Software reaches the block over a small 32-bit register bus with separate read and write strobes. The bus has a control register and two count registers.

Count writes land in staging registers and do not change the waveform. A write to the control register with the update bit set copies both staged counts into the active counts one cycle later. The same copy restarts the period at the beginning of its high phase. The phase counter runs only while the core enable bit is set. The pin drives only when the core enable bit and the output enable bit are both set. The intended sequence is to write both counts, then write the control register with core enable, output enable and update set together. Writing the control register as zero turns the pin off.

Top module: `oncyc_pwm`

## Requirements
- R1: The control register sits at offset 0x00. Bit 0 is core enable and bit 14 is output enable; both read back as written. Bit 5 is the update request, which always reads 0. Every other bit reads 0.
- R2: The low-phase count register is at offset 0x18 and the high-phase count register is at offset 0x1C. Each holds 32 bits and reads back the value last written, whether or not an update has followed.
- R3: Writing a count register does not change the waveform. One clock after a control write with bit 5 set, the staged counts become active and the phase counter restarts at the first high cycle. This copy happens even when the core is disabled.
- R4: With both enables set, one period lasts high count plus low count clocks. The pin is high for the first high-count clocks of each period and low for the rest.
- R5: The pin is 0 whenever core enable or output enable is 0.
- R6: An active high count of 0 keeps the pin low. A low count of 0 with a non-zero high count keeps it high. Both counts 0 keeps it low.
- R7: While core enable is 0 the phase counter is held at zero, so enabling the core begins a fresh high phase.
- R8: A read of any offset other than 0x00, 0x18 or 0x1C returns 0. A write to such an offset changes no register and no output.
- R9: After reset every register reads 0 and the pin is 0.
- R10: Read data appears on the clock edge at which the read strobe is sampled, and it holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; counts are measured in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Registered read data |
| pwmOut | output | 1 | Modulated output pin |

## Verification
The bench aims at the edges of the phase counter, where an off-by-one design would stretch or shorten a phase by one clock. It also aims at the zero-count cases, where a naive comparator would give a one-clock glitch or a wrapped counter. It writes counts without an update and checks that the waveform does not change, which catches a design that applies staged counts straight away. It also checks that an update restarts the period at the high phase, so a design that keeps counting from the old phase fails. Further checks cover a disable followed by a re-enable that must start a fresh high phase, the update bit that must always read 0, and writes to unmapped offsets that must leave all registers unchanged.

// File: rtl/oncyc_pwm_pkg.sv
package oncyc_pwm_pkg;
  // Register offsets (bytes)
  localparam int unsigned OFS_CTRL = 'h00;
  localparam int unsigned OFS_LOW  = 'h18;
  localparam int unsigned OFS_HIGH = 'h1C;

  // Control register bit positions
  localparam int unsigned BIT_CORE_EN = 0;
  localparam int unsigned BIT_UPDATE  = 5;
  localparam int unsigned BIT_OUT_EN  = 14;

  // Strobes from the register file to the phase datapath
  typedef struct packed {
    logic load;   // copy staged counts to active, restart phase
    logic run;    // core enabled: phase counter advances
    logic drive;  // both enables: pin may go high
  } pwmStrobes_t;
endpackage

// File: rtl/oncyc_pwm_ctrl.sv
module oncyc_pwm_ctrl
  import oncyc_pwm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] stageHigh,
  output logic [DATA_W-1:0] stageLow,
  output pwmStrobes_t       strobes
);
  logic coreEn, outEn, updPend;
  logic selCtrl, selLow, selHigh, selNone;
  logic [DATA_W-1:0] rdMux;

  assign selCtrl = (busAddr == ADDR_W'(OFS_CTRL));
  assign selLow  = (busAddr == ADDR_W'(OFS_LOW));
  assign selHigh = (busAddr == ADDR_W'(OFS_HIGH));
  assign selNone = !(selCtrl || selLow || selHigh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coreEn    <= 1'b0;
      outEn     <= 1'b0;
      updPend   <= 1'b0;
      stageHigh <= '0;
      stageLow  <= '0;
    end else begin
      updPend <= busWrEn && selCtrl && busWrData[BIT_UPDATE];
      if (busWrEn && selCtrl) begin
        coreEn <= busWrData[BIT_CORE_EN];
        outEn  <= busWrData[BIT_OUT_EN];
      end
      if (busWrEn && selLow)  stageLow  <= busWrData;
      if (busWrEn && selHigh) stageHigh <= busWrData;
    end
  end

  always_comb begin
    rdMux = '0;
    if (selCtrl) begin
      rdMux[BIT_CORE_EN] = coreEn;
      rdMux[BIT_OUT_EN]  = outEn;
    end else if (selLow) begin
      rdMux = stageLow;
    end else if (selHigh) begin
      rdMux = stageHigh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       busRdData <= '0;
    else if (busRdEn) busRdData <= rdMux;
  end

  assign strobes.load  = updPend;
  assign strobes.run   = coreEn;
  assign strobes.drive = coreEn && outEn;

  // Update request lasts one cycle unless software writes it again
  assert_update_selfclear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (updPend && !(busWrEn && selCtrl && busWrData[BIT_UPDATE])) |=> !updPend);

  // Unmapped reads return zero
  assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busRdEn && selNone) |=> (busRdData == '0));

  // Read data holds without a read strobe
  assert_rddata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busRdEn && !$past(!rst_n)) |=> $stable(busRdData));

  // Staged counts ignore writes to other offsets
  assert_stage_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busWrEn) |=> ($stable(stageHigh) && $stable(stageLow)));
endmodule

// File: rtl/oncyc_pwm_dp.sv
module oncyc_pwm_dp
  import oncyc_pwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pwmStrobes_t       strobes,
  input  logic [DATA_W-1:0] stageHigh,
  input  logic [DATA_W-1:0] stageLow,
  output logic              pwmOut
);
  localparam int unsigned CNT_W = DATA_W + 1;

  logic [DATA_W-1:0] actHigh, actLow;
  logic [CNT_W-1:0]  phaseCnt, periodLen;
  logic              lastCycle;

  assign periodLen = {1'b0, actHigh} + {1'b0, actLow};
  assign lastCycle = (periodLen == '0) || (phaseCnt >= periodLen - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      actHigh <= '0;
      actLow  <= '0;
    end else if (strobes.load) begin
      actHigh <= stageHigh;
      actLow  <= stageLow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          phaseCnt <= '0;
    else if (!strobes.run)               phaseCnt <= '0;
    else if (strobes.load || lastCycle)  phaseCnt <= '0;
    else                                 phaseCnt <= phaseCnt + CNT_W'(1);
  end

  assign pwmOut = strobes.drive && (phaseCnt < {1'b0, actHigh});

  // Counter parked while the core is off
  assert_cnt_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.run |=> (phaseCnt == '0));

  // Update loads staged counts and restarts the phase
  assert_load_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.load |=> (phaseCnt == '0 && actHigh == $past(stageHigh) && actLow == $past(stageLow)));

  // Phase stays inside the period
  assert_cnt_in_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseCnt == '0) || (phaseCnt < periodLen));

  // Active counts change only on a load
  assert_active_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.load |=> ($stable(actHigh) && $stable(actLow)));
endmodule

// File: rtl/oncyc_pwm.sv
module oncyc_pwm
  import oncyc_pwm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              pwmOut
);
  pwmStrobes_t       strobes;
  logic [DATA_W-1:0] stageHigh, stageLow;

  oncyc_pwm_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rst_n(rst_n),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .stageHigh(stageHigh), .stageLow(stageLow), .strobes(strobes)
  );

  oncyc_pwm_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .stageHigh(stageHigh), .stageLow(stageLow), .pwmOut(pwmOut)
  );

  // Pin quiet whenever the core enable is off
  assert_pin_low_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.run |-> !pwmOut);
endmodule

// File: tb/oncyc_pwm_test.sv
module oncyc_pwm_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        pwmOut;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 0;

  oncyc_pwm uut (.clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
                 .busAddr(busAddr), .busWrData(busWrData),
                 .busRdData(busRdData), .pwmOut(pwmOut));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  bit          mEn, mOen, mPend;
  longint      mShHi, mShLo, mActHi, mActLo, mCnt;
  logic [31:0] mRd;

  function automatic logic [31:0] modelRead(logic [7:0] a);
    if (a == 8'h00) return (32'(mEn) << 0) | (32'(mOen) << 14);
    if (a == 8'h18) return 32'(mShLo);
    if (a == 8'h1C) return 32'(mShHi);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mEn = 0; mOen = 0; mPend = 0; mShHi = 0; mShLo = 0;
      mActHi = 0; mActLo = 0; mCnt = 0; mRd = 0;
    end else begin
      longint per;
      bit nPend;
      per = mActHi + mActLo;
      if (busRdEn) mRd = modelRead(busAddr);
      if (!mEn) mCnt = 0;
      else if (mPend || per == 0 || mCnt >= per - 1) mCnt = 0;
      else mCnt = mCnt + 1;
      if (mPend) begin mActHi = mShHi; mActLo = mShLo; end
      nPend = busWrEn && busAddr == 8'h00 && busWrData[5];
      if (busWrEn && busAddr == 8'h00) begin mEn = busWrData[0]; mOen = busWrData[14]; end
      if (busWrEn && busAddr == 8'h18) mShLo = busWrData;
      if (busWrEn && busAddr == 8'h1C) mShHi = busWrData;
      mPend = nPend;
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // Every-clock comparison against the model (R4 waveform, R10 read data)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit expOut;
      expOut = mEn && mOen && (mCnt < mActHi);
      check(pwmOut == expOut, "R4 pin vs model", pwmOut, expOut);
      check(busRdData == mRd, "R10 read data vs model", busRdData, mRd);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk); busWrEn = 0; busWrData = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); busRdEn = 1; busAddr = a;
    @(negedge clk); busRdEn = 0; v = busRdData;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts high cycles over n clocks, sampled at negedges
  task automatic countHigh(int n, output int hi);
    hi = 0;
    repeat (n) begin @(negedge clk); if (pwmOut) hi++; end
  endtask

  initial begin
    logic [31:0] v;
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    check(pwmOut == 1'b0, "R9 pin after reset", pwmOut, 0);
    rd(8'h00, v); check(v == 0, "R9 ctrl after reset", v, 0);
    rd(8'h18, v); check(v == 0, "R9 low count after reset", v, 0);
    rd(8'h1C, v); check(v == 0, "R9 high count after reset", v, 0);

    // R2 staging readback
    wr(8'h1C, 32'd3); wr(8'h18, 32'd5);
    rd(8'h1C, v); check(v == 3, "R2 high count readback", v, 3);
    rd(8'h18, v); check(v == 5, "R2 low count readback", v, 5);

    // R1 ctrl fields, update self-clear
    wr(8'h00, 32'h0000_4021);
    rd(8'h00, v); check(v == 32'h4001, "R1 ctrl readback, update reads 0", v, 32'h4001);
    // R4 period 8, high 3
    countHigh(16, hi); check(hi == 6, "R4 high cycles in two periods", hi, 6);

    // R3 staged counts have no effect before update
    wr(8'h1C, 32'd1); wr(8'h18, 32'd1);
    countHigh(16, hi); check(hi == 6, "R3 staged counts ignored", hi, 6);
    wr(8'h00, 32'h0000_4021);
    countHigh(16, hi); check(hi == 8, "R3 new counts after update", hi, 8);

    // R5 each enable alone keeps the pin low
    wr(8'h00, 32'h0000_0001);
    countHigh(10, hi); check(hi == 0, "R5 core enable only", hi, 0);
    wr(8'h00, 32'h0000_4000);
    countHigh(10, hi); check(hi == 0, "R5 output enable only", hi, 0);

    // R6 zero counts
    wr(8'h1C, 32'd0); wr(8'h18, 32'd4); wr(8'h00, 32'h4021);
    countHigh(12, hi); check(hi == 0, "R6 zero high count", hi, 0);
    wr(8'h1C, 32'd4); wr(8'h18, 32'd0); wr(8'h00, 32'h4021);
    idle(1);
    countHigh(12, hi); check(hi == 12, "R6 zero low count", hi, 12);
    wr(8'h1C, 32'd0); wr(8'h18, 32'd0); wr(8'h00, 32'h4021);
    countHigh(12, hi); check(hi == 0, "R6 both counts zero", hi, 0);

    // R7 disable then re-enable starts fresh high phase; update while disabled loads (R3)
    wr(8'h1C, 32'd3); wr(8'h18, 32'd4); wr(8'h00, 32'h0000_0020);
    idle(3);
    @(negedge clk); busWrEn = 1; busAddr = 8'h00; busWrData = 32'h4001;
    @(negedge clk); busWrEn = 0;
    check(pwmOut == 1'b1, "R7 first cycle after enable high", pwmOut, 1);
    countHigh(2, hi); check(hi == 2, "R7 fresh high phase length", hi, 2);
    countHigh(4, hi); check(hi == 0, "R7 low phase follows", hi, 0);

    // R8 unmapped offsets
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF); wr(8'h19, 32'hFFFF_FFFF);
    rd(8'h04, v); check(v == 0, "R8 unmapped read 0x04", v, 0);
    rd(8'h1C, v); check(v == 3, "R8 high count untouched", v, 3);
    rd(8'h18, v); check(v == 4, "R8 low count untouched", v, 4);
    rd(8'h00, v); check(v == 32'h4001, "R8 ctrl untouched", v, 32'h4001);

    // R10 read data holds without strobe
    idle(5); check(busRdData == 32'h4001, "R10 read data held", busRdData, 32'h4001);

    // Disable via all-zero write
    wr(8'h00, 32'h0);
    countHigh(10, hi); check(hi == 0, "R5 all-zero ctrl disables", hi, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule